// File: doc/BRIEF.md
# Atomic Exchange-Add and Compare-Exchange Sequencer

This block carries out two read-modify-write operations on 16-bit words. The first is exchange-and-add. The second is compare-and-exchange against an accumulator. A start pulse launches one operation. The caller picks the operation, chooses whether the destination is a register or a memory word, and gives the destination and source register indices. The block then works through a fixed sequence of states. It reads the destination from the register file or from memory, computes the result and the six arithmetic flags, and performs the write-backs. A one-cycle done pulse ends the operation.

The register file sits outside the block. It has eight entries, and entry 0 serves as the accumulator. The block drives two combinational read addresses and takes a dedicated accumulator read. It owns the file's single write port, so each cycle carries at most one register write. A memory destination goes through a request/acknowledge port. A request is held until the acknowledge arrives, and read data is taken in the cycle that carries the acknowledge. Address generation, bus locking and decode are handled elsewhere.

Top module: `xchg_arith_unit`

## Requirements
- R1: Exchange-and-add with a register destination writes the old destination value into the source register first. In the next cycle it writes (dest + src) mod 2^16 into the destination register.
- R2: When exchange-and-add names the same register as source and destination, that register ends up holding the sum.
- R3: Exchange-and-add sets `flags` as the add dest + src. Bit 0 is carry out of bit 15. Bit 1 is set when the low result byte holds an even number of ones. Bit 2 is carry out of bit 3. Bit 3 is set for a zero result. Bit 4 is result bit 15. Bit 5 is signed overflow.
- R4: Compare-and-exchange sets `flags` as the subtraction accumulator − dest, using the same bit positions as R3. Bit 0 is the borrow, and bit 2 is the borrow out of bit 3.
- R5: Compare-and-exchange with a zero difference writes the source register value into the destination, which is a register or memory.
- R6: Compare-and-exchange with a nonzero difference writes the old destination value into register 0. With a register destination, no other register is written.
- R7: A memory destination is always read once and written once, in that order. A failed compare writes back the unchanged old value. Exchange-and-add with a memory destination then writes the old value to the source register.
- R8: `done` is high for exactly one cycle, after the last write of the operation. A `start` that arrives while an operation is in progress has no effect.
- R9: `mem_rd_req` and `mem_wr_req` stay high until `mem_ack`. `mem_wr_data` does not change while a write waits.
- R10: After reset, `done`, `rf_we`, `mem_rd_req` and `mem_wr_req` are low.
- R11: At most one register write occurs per cycle. The two register writes of a register exchange-and-add fall in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch an operation (taken only when idle) |
| op_cmpxchg | input | 1 | 0 = exchange-and-add, 1 = compare-and-exchange |
| dst_mem | input | 1 | 1 = destination is the memory word |
| dst_idx | input | 3 | Destination register index |
| src_idx | input | 3 | Source register index |
| done | output | 1 | One-cycle completion pulse |
| flags | output | 6 | {OF,SF,ZF,AF,PF,CF}, valid with done |
| rf_ra_addr | output | 3 | Read address for the destination register |
| rf_ra_data | input | 16 | Destination register value |
| rf_rb_addr | output | 3 | Read address for the source register |
| rf_rb_data | input | 16 | Source register value |
| rf_acc_data | input | 16 | Register 0 value |
| rf_we | output | 1 | Register write enable |
| rf_waddr | output | 3 | Register write index |
| rf_wdata | output | 16 | Register write data |
| mem_rd_req | output | 1 | Memory read request |
| mem_rd_data | input | 16 | Memory read data, valid with ack |
| mem_wr_req | output | 1 | Memory write request |
| mem_wr_data | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory handshake acknowledge |

## Verification
The bench aims at the aliasing case where source and destination are the same register. A design that put the two writes in the wrong order would leave the old value there instead of the sum. It drives operands that cross bit 15, the nibble boundary and the zero result, so that swapped operand order or a wrong borrow sense shows up in the flags. Failed compares are run on both destination kinds. A design that skipped the memory write-back would stall the handshake or drop an expected write, and one that wrote the register destination would produce an extra write. A second start pulse issued mid-operation would show up as spurious writes or an extra done if the design did not block it.

// File: rtl/xchg_arith_unit.sv
module xchg_arith_unit #(
  parameter int DATA_W = 16,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              op_cmpxchg,
  input  logic              dst_mem,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  output logic              done,
  output logic [5:0]        flags,
  output logic [IDX_W-1:0]  rf_ra_addr,
  input  logic [DATA_W-1:0] rf_ra_data,
  output logic [IDX_W-1:0]  rf_rb_addr,
  input  logic [DATA_W-1:0] rf_rb_data,
  input  logic [DATA_W-1:0] rf_acc_data,
  output logic              rf_we,
  output logic [IDX_W-1:0]  rf_waddr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              mem_rd_req,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wr_req,
  output logic [DATA_W-1:0] mem_wr_data,
  input  logic              mem_ack
);
  localparam logic [IDX_W-1:0] ACC = '0;

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_COMPUTE, S_WMEM, S_WREG1, S_WREG2, S_DONE
  } st_t;

  st_t st;
  logic              op_q, mem_q;
  logic [IDX_W-1:0]  dst_q, src_q;
  logic [DATA_W-1:0] dval_q, mwdata_q;
  logic              w1_en, w2_en;
  logic [IDX_W-1:0]  w1_addr, w2_addr;
  logic [DATA_W-1:0] w1_data, w2_data;
  logic [5:0]        flags_q;

  logic [DATA_W-1:0] d, s, a, res;
  logic [DATA_W:0]   add_w, sub_w;
  logic              cf, af, of, zero;

  assign d     = mem_q ? dval_q : rf_ra_data;
  assign s     = rf_rb_data;
  assign a     = rf_acc_data;
  assign add_w = {1'b0, d} + {1'b0, s};
  assign sub_w = {1'b0, a} - {1'b0, d};
  assign res   = op_q ? sub_w[DATA_W-1:0] : add_w[DATA_W-1:0];
  assign zero  = (res == '0);
  assign cf    = op_q ? sub_w[DATA_W] : add_w[DATA_W];
  assign af    = op_q ? (a[4] ^ d[4] ^ res[4]) : (d[4] ^ s[4] ^ res[4]);
  assign of    = op_q ? ((a[DATA_W-1] != d[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]))
                      : ((d[DATA_W-1] == s[DATA_W-1]) && (res[DATA_W-1] != d[DATA_W-1]));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op_q <= 1'b0; mem_q <= 1'b0; dst_q <= '0; src_q <= '0;
      dval_q <= '0; mwdata_q <= '0; flags_q <= '0;
      w1_en <= 1'b0; w2_en <= 1'b0;
      w1_addr <= '0; w2_addr <= '0; w1_data <= '0; w2_data <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          op_q <= op_cmpxchg; mem_q <= dst_mem;
          dst_q <= dst_idx; src_q <= src_idx;
          st <= dst_mem ? S_READ : S_COMPUTE;
        end
        S_READ: if (mem_ack) begin
          dval_q <= mem_rd_data;
          st <= S_COMPUTE;
        end
        S_COMPUTE: begin
          flags_q <= {of, res[DATA_W-1], zero, af, ~^res[7:0], cf};
          w2_en <= 1'b0; w2_addr <= dst_q; w2_data <= add_w[DATA_W-1:0];
          if (!op_q) begin
            mwdata_q <= add_w[DATA_W-1:0];
            w1_en <= 1'b1; w1_addr <= src_q; w1_data <= d;
            w2_en <= !mem_q;
          end else if (zero) begin
            mwdata_q <= s;
            w1_en <= !mem_q; w1_addr <= dst_q; w1_data <= s;
          end else begin
            mwdata_q <= d;
            w1_en <= 1'b1; w1_addr <= ACC; w1_data <= d;
          end
          st <= mem_q ? S_WMEM : S_WREG1;
        end
        S_WMEM:  if (mem_ack) st <= w1_en ? S_WREG1 : S_DONE;
        S_WREG1: st <= w2_en ? S_WREG2 : S_DONE;
        S_WREG2: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign rf_ra_addr  = dst_q;
  assign rf_rb_addr  = src_q;
  assign rf_we       = (st == S_WREG1) || (st == S_WREG2);
  assign rf_waddr    = (st == S_WREG2) ? w2_addr : w1_addr;
  assign rf_wdata    = (st == S_WREG2) ? w2_data : w1_data;
  assign mem_rd_req  = (st == S_READ);
  assign mem_wr_req  = (st == S_WMEM);
  assign mem_wr_data = mwdata_q;
  assign done        = (st == S_DONE);
  assign flags       = flags_q;

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !rf_we && !mem_wr_req && !mem_rd_req);
  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_req && !mem_ack) |=> mem_wr_req && $stable(mem_wr_data));
  a_r9_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_ack) |=> mem_rd_req);
  a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && mem_ack) |=> ##1 mem_wr_req);
  a_r6_reg_fail_acc_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && op_q && !mem_q && !flags_q[3]) |-> rf_waddr == ACC);
  a_r11_pair_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WREG2) |-> $past(rf_we) && rf_we);
endmodule

// File: tb/xchg_arith_unit_tb_top.sv
module xchg_arith_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        start = 0, op_cmpxchg = 0, dst_mem = 0;
  logic [2:0]  dst_idx = 0, src_idx = 0;
  logic        done, rf_we, mem_rd_req, mem_wr_req;
  logic [5:0]  flags;
  logic [2:0]  rf_ra_addr, rf_rb_addr, rf_waddr;
  logic [15:0] rf_wdata, mem_wr_data;
  logic [15:0] mem_rd_data = 0;
  logic        mem_ack = 0;
  logic [15:0] rf [8];
  logic [15:0] memword;

  xchg_arith_unit dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_cmpxchg(op_cmpxchg),
    .dst_mem(dst_mem), .dst_idx(dst_idx), .src_idx(src_idx),
    .done(done), .flags(flags),
    .rf_ra_addr(rf_ra_addr), .rf_ra_data(rf[rf_ra_addr]),
    .rf_rb_addr(rf_rb_addr), .rf_rb_data(rf[rf_rb_addr]),
    .rf_acc_data(rf[0]),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_rd_req(mem_rd_req), .mem_rd_data(mem_rd_data),
    .mem_wr_req(mem_wr_req), .mem_wr_data(mem_wr_data), .mem_ack(mem_ack));

  typedef struct packed {
    logic [1:0]  kind;   // 0 reg write, 1 mem write, 2 done
    logic [2:0]  addr;
    logic [15:0] data;
    logic        consec;
    logic [5:0]  fl;
  } ev_t;
  ev_t exp_q[$];

  int compared = 0, mismatched = 0, done_cnt = 0, cyc = 0, last_we = -10;
  int lat = 1, wcnt = 0;
  logic prev_done = 0;

  task automatic chk(string req, logic ok, logic [31:0] act, logic [31:0] expv);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [5:0] fl_of(input bit sub, input logic [15:0] x, input logic [15:0] y);
    logic [16:0] r; logic [15:0] t; logic o;
    r = sub ? ({1'b0, x} - {1'b0, y}) : ({1'b0, x} + {1'b0, y});
    t = x ^ y ^ r[15:0];
    o = sub ? ((x[15] != y[15]) && (r[15] != x[15])) : ((x[15] == y[15]) && (r[15] != x[15]));
    return {o, r[15], r[15:0] == 16'h0, t[4], ~^r[7:0], r[16]};
  endfunction

  function automatic ev_t mk(logic [1:0] k, logic [2:0] ad, logic [15:0] dt, logic c, logic [5:0] f);
    ev_t e; e.kind = k; e.addr = ad; e.data = dt; e.consec = c; e.fl = f; return e;
  endfunction

  always @(posedge clk) if (rf_we) rf[rf_waddr] <= rf_wdata;

  always @(negedge clk) begin
    ev_t e;
    cyc++;
    if (rst_n) begin
      if (rf_we) begin
        if (exp_q.size() == 0 || exp_q[0].kind != 0)
          chk("R6/R8 unexpected register write", 1'b0, {rf_waddr, rf_wdata}, 0);
        else begin
          e = exp_q.pop_front();
          chk("R1/R2/R5/R6 register write", rf_waddr == e.addr && rf_wdata == e.data,
              {rf_waddr, rf_wdata}, {e.addr, e.data});
          if (e.consec) chk("R11 consecutive writes", cyc - last_we == 1, cyc - last_we, 1);
        end
        last_we = cyc;
      end
      if ((mem_rd_req || mem_wr_req) && !mem_ack) begin
        if (wcnt == lat) begin
          mem_ack <= 1'b1;
          mem_rd_data <= memword;
          wcnt = 0;
          if (mem_wr_req) begin
            if (exp_q.size() == 0 || exp_q[0].kind != 1)
              chk("R7 unexpected memory write", 1'b0, mem_wr_data, 0);
            else begin
              e = exp_q.pop_front();
              chk("R5/R7 memory write data", mem_wr_data == e.data, mem_wr_data, e.data);
            end
            memword = mem_wr_data;
          end
        end else wcnt++;
      end else mem_ack <= 1'b0;
      if (done) begin
        chk("R8 done one cycle", !prev_done, prev_done, 0);
        if (exp_q.size() == 0 || exp_q[0].kind != 2)
          chk("R8 unexpected done", 1'b0, exp_q.size(), 0);
        else begin
          e = exp_q.pop_front();
          chk("R3/R4 flags", flags == e.fl, flags, e.fl);
        end
        done_cnt++;
      end
      prev_done = done;
    end
  end

  task automatic run_op(bit cmp, bit m, logic [2:0] di, logic [2:0] si, bit extra_start);
    logic [15:0] d, s, a, r; int n;
    d = m ? memword : rf[di]; s = rf[si]; a = rf[0];
    if (!cmp) begin
      r = d + s;
      if (m) begin
        exp_q.push_back(mk(1, 0, r, 0, 0));
        exp_q.push_back(mk(0, si, d, 0, 0));
      end else begin
        exp_q.push_back(mk(0, si, d, 0, 0));
        exp_q.push_back(mk(0, di, r, 1, 0));
      end
      exp_q.push_back(mk(2, 0, 0, 0, fl_of(0, d, s)));
    end else begin
      r = a - d;
      if (m) exp_q.push_back(mk(1, 0, (r == 0) ? s : d, 0, 0));
      if (r == 0) begin
        if (!m) exp_q.push_back(mk(0, di, s, 0, 0));
      end else exp_q.push_back(mk(0, 0, d, 0, 0));
      exp_q.push_back(mk(2, 0, 0, 0, fl_of(1, a, d)));
    end
    n = done_cnt;
    @(negedge clk);
    op_cmpxchg = cmp; dst_mem = m; dst_idx = di; src_idx = si; start = 1;
    @(negedge clk);
    start = 0;
    if (extra_start) begin
      @(negedge clk);
      op_cmpxchg = ~cmp; dst_mem = ~m; dst_idx = 3'd7; src_idx = 3'd6; start = 1;
      @(negedge clk);
      start = 0;
    end
    while (done_cnt == n) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R8 all expected events seen", exp_q.size() == 0, exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 8; i++) rf[i] = 16'h1000 * i[15:0] + 16'h0011;
    memword = 16'h4321;
    repeat (3) @(negedge clk);
    chk("R10 reset outputs", !done && !rf_we && !mem_rd_req && !mem_wr_req,
        {done, rf_we, mem_rd_req, mem_wr_req}, 0);
    rst_n = 1;
    @(negedge clk);
    rf[3] = 16'h1234; rf[5] = 16'h0F0F;
    run_op(0, 0, 3, 5, 0);                 // R1 R3
    chk("R1 dest sum", rf[3] == 16'h2143, rf[3], 16'h2143);
    chk("R1 src old dest", rf[5] == 16'h1234, rf[5], 16'h1234);
    rf[1] = 16'h7FFF; rf[2] = 16'h0001;
    run_op(0, 0, 1, 2, 0);                 // R3 overflow
    rf[1] = 16'hFFFF; rf[2] = 16'h0001;
    run_op(0, 0, 1, 2, 0);                 // R3 carry, zero
    rf[4] = 16'h0123;
    run_op(0, 0, 4, 4, 0);                 // R2 aliasing
    chk("R2 same register holds sum", rf[4] == 16'h0246, rf[4], 16'h0246);
    lat = 2; memword = 16'h8000; rf[6] = 16'h8000;
    run_op(0, 1, 0, 6, 0);                 // R7 xadd mem
    chk("R7 memory sum", memword == 16'h0000, memword, 0);
    chk("R7 src gets old mem", rf[6] == 16'h8000, rf[6], 16'h8000);
    rf[0] = 16'h0050; rf[3] = 16'h0050; rf[5] = 16'hBEEF;
    run_op(1, 0, 3, 5, 0);                 // R5 reg eq
    chk("R5 dest gets src", rf[3] == 16'hBEEF, rf[3], 16'hBEEF);
    rf[0] = 16'h0010; rf[3] = 16'h0021;
    run_op(1, 0, 3, 5, 0);                 // R6 reg neq, borrow
    chk("R6 acc gets dest", rf[0] == 16'h0021, rf[0], 16'h0021);
    chk("R6 dest unchanged", rf[3] == 16'h0021, rf[3], 16'h0021);
    lat = 0; memword = 16'h0021; rf[7] = 16'h5A5A;
    run_op(1, 1, 0, 7, 0);                 // R5 mem eq
    chk("R5 mem gets src", memword == 16'h5A5A, memword, 16'h5A5A);
    lat = 3; rf[0] = 16'h8000; memword = 16'h0001;
    run_op(1, 1, 0, 7, 0);                 // R7 mem neq, overflow
    chk("R7 mem unchanged", memword == 16'h0001, memword, 16'h0001);
    chk("R6 acc from mem", rf[0] == 16'h0001, rf[0], 16'h0001);
    rf[2] = 16'h0777;
    run_op(1, 0, 0, 2, 0);                 // R5 dest is acc itself
    chk("R5 acc dest replaced", rf[0] == 16'h0777, rf[0], 16'h0777);
    lat = 1; rf[1] = 16'h000F; rf[2] = 16'h0001;
    run_op(0, 0, 1, 2, 1);                 // R8 start while busy ignored
    chk("R8 busy start ignored", rf[1] == 16'h0010 && rf[7] == 16'h5A5A, rf[1], 16'h0010);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", done_cnt, 11);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule